// File: doc/BRIEF.md
# Byte FIFO with Occupancy Register and Flush

This block is a 64-byte, 8-bit first-in first-out buffer. One side is a host register port and the other is an internal producer. The host port decodes two registers. The data register pushes a byte when written and pops the oldest byte when read. The occupancy register reports how many bytes are stored. Writing the occupancy register with its top bit set acts as a one-shot flush command. The internal producer offers bytes through a request/ready pair. Because the host port has priority, the producer waits one cycle whenever the host writes.

A sticky overflow flag records any attempt to push into a full buffer, whichever side made it. Only a flush or a pulse on the explicit clear input lowers it.

Top module: `byteFifoLevel`

## Requirements
- R1: After reset the occupancy is 0, the overflow flag is 0, and reading the occupancy register (hostAddr = 1) returns 0x00.
- R2: A host write to the data register (hostAddr = 0) while not full stores the byte and raises the occupancy by one on the next clock edge.
- R3: A host read of the data register while not empty returns the oldest stored byte combinationally in the same cycle and lowers the occupancy by one at the clock edge. Bytes come out in the order they were stored, from both ports combined.
- R4: A host read of the occupancy register returns the stored byte count in bits 6:0, and bit 7 always reads 0.
- R5: A host write to the occupancy register with bit 7 = 1 empties the buffer and clears the overflow flag at the next edge. A write to it with bit 7 = 0 changes nothing.
- R6: A host write to the data register while 64 bytes are stored is discarded. The stored bytes and the occupancy are unchanged, and the overflow flag is set.
- R7: An accepted internal write while the buffer is full is discarded and sets the overflow flag.
- R8: A host read of the data register while empty returns 0x00 and the occupancy stays 0.
- R9: In any cycle with hostWrEn = 1, intWrReady is 0 and the internal byte is not taken. A held request is accepted in the next cycle without a host write.
- R10: errClr = 1 clears the overflow flag at the next edge, unless an overflow occurs in the same cycle, in which case the flag is set.
- R11: The occupancy never exceeds 64. A host pop and an internal push in the same cycle leave it unchanged. Fullness is judged on the occupancy at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe (has priority over hostRdEn) |
| hostRdEn | input | 1 | Host register read strobe |
| hostAddr | input | 1 | Register select: 0 data, 1 occupancy |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, valid while hostRdEn is high |
| intWrEn | input | 1 | Internal producer push request |
| intWrData | input | 8 | Internal producer byte |
| intWrReady | output | 1 | Internal request taken this cycle when high |
| errClr | input | 1 | Clears the overflow flag |
| level | output | 7 | Stored byte count |
| ovflErr | output | 1 | Sticky overflow flag |

## Verification
The bench targets the full boundary from both sides. A design that judged fullness after a same-cycle pop would accept a 65th byte. A design that overwrote the head would return corrupted data after an overflow. At the empty boundary it checks that a pop returns zero and does not wrap the count below zero. It also checks that a host write steals the cycle from the internal producer without losing or reordering the held byte. A wrong arbiter would duplicate or drop that byte, which shows up in the drained order. A flush that fails to reset both pointers, or a flag that stays set after flush or clear, shows as an occupancy or flag mismatch in the following cycle.

// File: rtl/byteFifoPkg.sv
package byteFifoPkg;
  localparam int BYTE_W = 8;
  localparam logic ADDR_DATA  = 1'b0;
  localparam logic ADDR_LEVEL = 1'b1;

  typedef struct packed {
    logic push;
    logic fromHost;
    logic pop;
    logic flush;
  } fifoStrobeT;
endpackage

// File: rtl/byteFifoCtrl.sv
module byteFifoCtrl
  import byteFifoPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              intWrEn,
  input  logic              errClr,
  input  logic [BYTE_W-1:0] headData,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              intWrReady,
  output fifoStrobeT        strobe,
  output logic [CW-1:0]     count,
  output logic              ovflErr
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic hostDataWr, hostLevelWr, hostDataRd, intTry;
  logic isFull, isEmpty, overflow;

  always_comb begin
    hostDataWr  = hostWrEn && (hostAddr == ADDR_DATA);
    hostLevelWr = hostWrEn && (hostAddr == ADDR_LEVEL);
    hostDataRd  = hostRdEn && !hostWrEn && (hostAddr == ADDR_DATA);
    isFull      = (count == FULL_CNT);
    isEmpty     = (count == '0);
    intWrReady  = !hostWrEn;
    intTry      = intWrEn && intWrReady;
    overflow    = (hostDataWr || intTry) && isFull;
    strobe.flush    = hostLevelWr && hostWrData[BYTE_W-1];
    strobe.fromHost = hostDataWr;
    strobe.push     = (hostDataWr || intTry) && !isFull;
    strobe.pop      = hostDataRd && !isEmpty;
  end

  always_comb begin
    hostRdData = '0;
    if (hostRdEn) begin
      if (hostAddr == ADDR_LEVEL) hostRdData = BYTE_W'(count);
      else if (!isEmpty)          hostRdData = headData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      ovflErr <= 1'b0;
    end else if (strobe.flush) begin
      count   <= '0;
      ovflErr <= 1'b0;
    end else begin
      count <= count + CW'(strobe.push) - CW'(strobe.pop);
      if (overflow)    ovflErr <= 1'b1;
      else if (errClr) ovflErr <= 1'b0;
    end
  end
endmodule

// File: rtl/byteFifoStore.sv
module byteFifoStore
  import byteFifoPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strobe,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [BYTE_W-1:0] intWrData,
  output logic [BYTE_W-1:0] headData
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush)
      mem[wrPtr] <= strobe.fromHost ? hostWrData : intWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end
endmodule

// File: rtl/byteFifoLevel.sv
module byteFifoLevel
  import byteFifoPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              intWrEn,
  input  logic [BYTE_W-1:0] intWrData,
  output logic              intWrReady,
  input  logic              errClr,
  output logic [CW-1:0]     level,
  output logic              ovflErr
);
  fifoStrobeT strobe;
  logic [BYTE_W-1:0] headData;

  byteFifoCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .intWrEn(intWrEn),
    .errClr(errClr), .headData(headData), .hostRdData(hostRdData),
    .intWrReady(intWrReady), .strobe(strobe), .count(level), .ovflErr(ovflErr)
  );

  byteFifoStore #(.DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrData(hostWrData),
    .intWrData(intWrData), .headData(headData)
  );
endmodule

// File: rtl/byteFifoChecker.sv
module byteFifoChecker #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostWrEn,
  input logic          hostRdEn,
  input logic          hostAddr,
  input logic [7:0]    hostWrData,
  input logic [7:0]    hostRdData,
  input logic          intWrEn,
  input logic          intWrReady,
  input logic          errClr,
  input logic [CW-1:0] level,
  input logic          ovflErr
);
  logic atFull;
  assign atFull = (int'(level) == DEPTH);

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH);

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr && hostWrData[7]) |=> (level == '0 && !ovflErr));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !hostAddr && atFull) |=> (ovflErr && $stable(level)));

  assert_int_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intWrEn && intWrReady && atFull && !hostRdEn) |=> (ovflErr && $stable(level)));

  assert_bit7_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && hostAddr) |-> !hostRdData[7]);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && !hostWrEn && !hostAddr && level == '0) |-> (hostRdData == 8'h00));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> !intWrReady);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !(atFull && ((hostWrEn && !hostAddr) || (intWrEn && intWrReady))))
      |=> !ovflErr);
endmodule

bind byteFifoLevel byteFifoChecker #(.DEPTH(DEPTH)) uChecker (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
  .intWrEn(intWrEn), .intWrReady(intWrReady), .errClr(errClr),
  .level(level), .ovflErr(ovflErr)
);

// File: tb/tb_byteFifoLevel.sv
module tb_byteFifoLevel;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 0, hostRdEn = 0, hostAddr = 0, intWrEn = 0, errClr = 0;
  logic [7:0] hostWrData = 0, intWrData = 0, hostRdData;
  logic intWrReady, ovflErr;
  logic [6:0] level;

  int tests = 0, fails = 0;
  logic [7:0] q[$];
  logic expErr = 0;
  logic pend = 0;
  logic [7:0] pData = 0;
  string curReq = "R2";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byteFifoLevel #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .intWrEn(intWrEn), .intWrData(intWrData), .intWrReady(intWrReady),
    .errClr(errClr), .level(level), .ovflErr(ovflErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic a);
    if (a) return 8'(q.size());
    return (q.size() == 0) ? 8'h00 : q[0];
  endfunction

  // one cycle: drive at negedge, check combinational outputs, update model, check registered outputs
  task automatic step(input logic w, input logic r, input logic a, input logic [7:0] d,
                      input logic ec);
    bit wasFull, wasEmpty, ovf, intAcc;
    hostWrEn = w; hostRdEn = r; hostAddr = a; hostWrData = d; errClr = ec;
    intWrEn = pend; intWrData = pData;
    #1;
    chk(intWrReady == !w, "R9", intWrReady, !w);
    if (r && !w)
      chk(hostRdData == expRead(a), a ? "R4" : (q.size() == 0 ? "R8" : "R3"),
          hostRdData, expRead(a));
    wasFull = (q.size() == DEPTH);
    wasEmpty = (q.size() == 0);
    ovf = 0;
    intAcc = pend && !w;
    if (w && a && d[7]) begin
      q.delete();
      expErr = 0;
    end else begin
      if (w && !a) begin
        if (wasFull) ovf = 1; else q.push_back(d);
      end
      if (r && !w && !a && !wasEmpty) void'(q.pop_front());
      if (intAcc) begin
        if (wasFull) ovf = 1; else q.push_back(pData);
      end
      if (ovf) expErr = 1; else if (ec) expErr = 0;
    end
    if (intAcc) pend = 0;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 0; hostRdEn = 0; errClr = 0; intWrEn = 0;
    #1;
    chk(int'(level) == q.size(), curReq, level, q.size());
    chk(ovflErr == expErr, curReq, ovflErr, expErr);
  endtask

  task automatic hostWrite(input logic [7:0] d); step(1, 0, 0, d, 0); endtask
  task automatic hostRead(); step(0, 1, 0, 8'h00, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(level == 0, "R1", level, 0);
    chk(ovflErr == 0, "R1", ovflErr, 0);
    hostRdEn = 1; hostAddr = 1; #1;
    chk(hostRdData == 8'h00, "R1", hostRdData, 0);
    hostRdEn = 0; hostAddr = 0;
    @(negedge clk);

    // R2 / R3 push and ordered pop
    curReq = "R2";
    hostWrite(8'hA5); hostWrite(8'h3C); hostWrite(8'hF0);
    curReq = "R4"; step(0, 1, 1, 0, 0);
    curReq = "R3"; hostRead(); hostRead(); hostRead();
    // R8 read while empty
    curReq = "R8"; hostRead(); hostRead();

    // R6 fill then overflow from host, contents kept
    curReq = "R6";
    for (int i = 0; i < DEPTH; i++) hostWrite(8'(i * 3 + 1));
    step(0, 1, 1, 0, 0);
    hostWrite(8'hEE);
    hostWrite(8'hDD);
    // R10 clear
    curReq = "R10"; step(0, 0, 0, 0, 1);
    // R7 internal write while full
    curReq = "R7"; pend = 1; pData = 8'h77; step(0, 0, 0, 0, 0);
    // R11 pop plus internal push at full: fullness judged on start count
    curReq = "R11"; pend = 1; pData = 8'h55; step(0, 1, 0, 0, 1);
    // R5 level write without bit 7 does nothing; with bit 7 flushes
    curReq = "R5"; step(1, 0, 1, 8'h7F, 0);
    step(1, 0, 1, 8'h80, 0);
    hostRead();
    // R9 host write steals the cycle, held byte goes next
    curReq = "R9"; pend = 1; pData = 8'h42;
    hostWrite(8'h11);
    step(0, 0, 0, 0, 0);
    curReq = "R3"; hostRead(); hostRead();
    // R11 push and pop balance
    curReq = "R11"; hostWrite(8'h99);
    pend = 1; pData = 8'h66; hostRead();
    hostRead(); hostRead();

    // constrained random mix
    curReq = "R11";
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic w, r, a, ec;
      logic [7:0] d;
      if (!pend && ($urandom % 3 == 0)) begin pend = 1; pData = 8'($urandom); end
      sel = $urandom % 100;
      w = (sel < 40); r = (sel >= 40 && sel < 85);
      a = ($urandom % 16 == 0);
      d = 8'($urandom);
      if (w && a && ($urandom % 8 != 0)) d[7] = 1'b0;
      ec = ($urandom % 32 == 0);
      step(w, r, a, d, ec);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule